// File: doc/BRIEF.md
# Display PLL Configuration Word Calculator

This block turns two clock figures, a reference frequency in kHz and a wanted per-lane serial bit rate in kbps, into the 16-bit configuration word for the PLL of a serial display bridge. It also gives the PLL frequency that the word selects and the 6-bit low-power clock divider field that goes with it. A caller presents both figures with a one-cycle start strobe. It then waits for a one-cycle done pulse, at which point the word, the frequency and the divider field are valid. They stay valid until the next result.

The work is done in sequence. A search unit steps the pre-divider upward for as long as the divided reference stays at or above a 5 MHz floor. One restoring shift-subtract divider is then used four times: once for the rounded-up multiplier, once for the untruncated PLL frequency that selects the range band, once for the frequency implied by the packed word, and once for the rounded-up low-power divider. No wide combinational divide exists anywhere. A zero reference frequency is refused at once with an error flag.

Top module: `pllcfg_calc`

## Requirements
- R1: A start pulse is accepted only while `busy` is low, and it captures both inputs. `busy` is high from the next cycle until the cycle in which `done` rises. A start pulse while `busy` is high has no effect on the result being computed.
- R2: A start with `ref_khz` equal to zero gives, one cycle later, `done` and `err` both high for one cycle. In that cycle `cfg_word`, `pll_khz` and `lp_div_field` are zero, and `busy` stays low.
- R3: The pre-divider P begins at 1. It is raised by one while floor(`ref_khz` / (P+1)) is at least 5000, and it never exceeds 31. P is placed in `cfg_word` bits 12:8.
- R4: The multiplier M is ceil(`lane_kbps` × P / `ref_khz`). Its low 8 bits are placed in `cfg_word` bits 7:0.
- R5: The band code in `cfg_word` bits 15:14 is taken from F = floor(`ref_khz` × M / P) with the full, untruncated M. The code is 3 when F ≥ 501000, 2 when F ≥ 251000, 1 when F ≥ 126000, and 0 otherwise.
- R6: `cfg_word` bit 13 is always zero on a successful result. With R3 to R5, the word is {band, 0, P, M[7:0]}.
- R7: `pll_khz` is floor(`ref_khz` × M' / P). M' is the 8-bit multiplier field, taken as 1 when that field is zero.
- R8: `lp_div_field` is (ceil(`pll_khz` / 80000) − 1) modulo 64.
- R9: `done` is high for exactly one cycle per result, with `busy` low in that cycle. `err` is low on a successful result. `cfg_word`, `pll_khz` and `lp_div_field` change only in a cycle where `done` is high.
- R10: While reset is held and after it is released, `busy`, `done`, `err`, `cfg_word`, `pll_khz` and `lp_div_field` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute |
| ref_khz | input | 20 | Reference frequency in kHz |
| lane_kbps | input | 20 | Wanted per-lane bit rate in kbps |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Zero reference refused (valid with done) |
| cfg_word | output | 16 | Packed band, pre-divider and multiplier |
| pll_khz | output | 28 | PLL frequency implied by cfg_word |
| lp_div_field | output | 6 | Low-power clock divider field |

## Verification
A hand-worked pair (20 MHz reference, 500 Mbps lane rate) pins down the exact word, frequency and divider field. Other references exercise each end of the pre-divider search: one below 10 MHz keeps P at 1, and one large enough shows the cap at 31. Pairs that land exactly on each band threshold, and one step below it, separate a greater-or-equal compare from a strict one. Further cases cover a multiplier above 255, which separates the full-width band decision from the truncated field and frequency, and a zero lane rate, which shows the zero-field-as-one rule. A zero reference, a start issued mid-calculation and a run of idle cycles after a result check the error path, the ignored strobe and output holding.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int FREQ_W  = 20;
    localparam int PDIV_W  = 5;
    localparam int MULT_W  = 8;
    localparam int LP_W    = 6;
    localparam int BAND_W  = 2;
    localparam int NBANDS  = 3;

    localparam int MULQ_W  = FREQ_W + PDIV_W;
    localparam int WIDE_W  = 2 * FREQ_W + PDIV_W;
    localparam int PLL_W   = FREQ_W + MULT_W;
    localparam int WORD_W  = BAND_W + 1 + PDIV_W + MULT_W;

    localparam int unsigned PDIV_MAX    = 31;
    localparam int unsigned FLOOR_KHZ   = 5000;
    localparam int unsigned LP_STEP_KHZ = 80000;

    localparam int TH_W  = $clog2(FLOOR_KHZ * (PDIV_MAX + 1) + 1);
    localparam int CMP_W = (TH_W + 1 > FREQ_W) ? TH_W + 1 : FREQ_W;

    localparam logic [31:0] BAND_FLOOR [NBANDS] = '{32'd126000, 32'd251000, 32'd501000};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_MULT,
        ST_FULL,
        ST_FIELD,
        ST_LP
    } calc_state_e;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic              rsvd;
        logic [PDIV_W-1:0] prediv;
        logic [MULT_W-1:0] mult;
    } cfg_word_t;

    function automatic logic [MULT_W-1:0] mult_nonzero(input logic [MULT_W-1:0] m);
        return (m == '0) ? MULT_W'(1) : m;
    endfunction

endpackage

// File: rtl/pllcfg_shdiv.sv
module pllcfg_shdiv #(
    parameter int W = 45
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quot
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     dvs_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             fin_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvs_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                dvs_q <= divisor;
                quo_q <= dividend;
                rem_q <= '0;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign quot = quo_q;

    // R4: a finished quotient leaves a remainder below the divisor
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> (rem_q < dvs_q));

    // R1: the controller never restarts a divide in progress
    p_no_restart_r1: assert property (@(posedge clk) disable iff (rst)
        go |-> !run_q);

endmodule

// File: rtl/pllcfg_search.sv
module pllcfg_search
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [FREQ_W-1:0] ref_khz,
    output logic              fin,
    output logic [PDIV_W-1:0] prediv
);
    logic [CMP_W-1:0]  ref_q;
    logic [CMP_W-1:0]  thr_q;
    logic [PDIV_W-1:0] pd_q;
    logic              run_q;
    logic              fin_q;
    logic              step;

    assign step = (ref_q >= thr_q) && (pd_q < PDIV_W'(PDIV_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            thr_q <= '0;
            pd_q  <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                ref_q <= CMP_W'(ref_khz);
                thr_q <= CMP_W'(2 * FLOOR_KHZ);
                pd_q  <= PDIV_W'(1);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (step) begin
                    pd_q  <= pd_q + PDIV_W'(1);
                    thr_q <= thr_q + CMP_W'(FLOOR_KHZ);
                end else begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin    = fin_q;
    assign prediv = pd_q;

    // R3: the result lies in 1..31
    p_prediv_cap_r3: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> (pd_q != '0) && (pd_q <= PDIV_W'(PDIV_MAX)));

    // R3: every step taken kept the divided reference at or above the floor
    p_prediv_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (fin_q && pd_q > PDIV_W'(1)) |-> (ref_q >= CMP_W'(FLOOR_KHZ) * CMP_W'(pd_q)));

endmodule

// File: rtl/pllcfg_band.sv
module pllcfg_band
    import pllcfg_pkg::*;
(
    input  logic [WIDE_W-1:0] freq_khz,
    output logic [BAND_W-1:0] band
);
    logic [NBANDS-1:0] hit;

    for (genvar i = 0; i < NBANDS; i++) begin : g_floor
        assign hit[i] = (freq_khz >= WIDE_W'(BAND_FLOOR[i]));
    end

    assign band = BAND_W'($countones(hit));

endmodule

// File: rtl/pllcfg_calc.sv
module pllcfg_calc
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_khz,
    input  logic [FREQ_W-1:0] lane_kbps,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] cfg_word,
    output logic [PLL_W-1:0]  pll_khz,
    output logic [LP_W-1:0]   lp_div_field
);
    calc_state_e       state_q;
    logic [FREQ_W-1:0] ref_q;
    logic [FREQ_W-1:0] rate_q;
    logic [PDIV_W-1:0] pdiv_q;
    logic [MULT_W-1:0] mfield_q;
    logic [BAND_W-1:0] band_q;
    logic [PLL_W-1:0]  pllf_q;

    logic              srch_go_q;
    logic              srch_fin;
    logic [PDIV_W-1:0] srch_pdiv;

    logic              div_go_q;
    logic [WIDE_W-1:0] dvd_q;
    logic [WIDE_W-1:0] dvs_q;
    logic              div_fin;
    logic [WIDE_W-1:0] quot;
    logic [BAND_W-1:0] quot_band;

    cfg_word_t         word_q;
    logic [PLL_W-1:0]  pll_q;
    logic [LP_W-1:0]   lp_q;
    logic              done_q;
    logic              err_q;

    logic [WIDE_W-1:0] ceil_dvd;
    logic [WIDE_W-1:0] full_dvd;
    logic [WIDE_W-1:0] field_dvd;
    logic [WIDE_W-1:0] lp_dvd;

    pllcfg_search u_search (
        .clk     (clk),
        .rst     (rst),
        .go      (srch_go_q),
        .ref_khz (ref_q),
        .fin     (srch_fin),
        .prediv  (srch_pdiv)
    );

    pllcfg_shdiv #(.W(WIDE_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go_q),
        .dividend (dvd_q),
        .divisor  (dvs_q),
        .fin      (div_fin),
        .quot     (quot)
    );

    pllcfg_band u_band (
        .freq_khz (quot),
        .band     (quot_band)
    );

    always_comb begin
        ceil_dvd  = WIDE_W'(rate_q) * WIDE_W'(srch_pdiv) + WIDE_W'(ref_q) - WIDE_W'(1);
        full_dvd  = WIDE_W'(ref_q) * WIDE_W'(quot[MULQ_W-1:0]);
        field_dvd = WIDE_W'(ref_q) * WIDE_W'(mult_nonzero(mfield_q));
        lp_dvd    = quot + WIDE_W'(LP_STEP_KHZ - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ref_q     <= '0;
            rate_q    <= '0;
            pdiv_q    <= '0;
            mfield_q  <= '0;
            band_q    <= '0;
            pllf_q    <= '0;
            srch_go_q <= 1'b0;
            div_go_q  <= 1'b0;
            dvd_q     <= '0;
            dvs_q     <= '0;
            word_q    <= '0;
            pll_q     <= '0;
            lp_q      <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            srch_go_q <= 1'b0;
            div_go_q  <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ref_q  <= ref_khz;
                        rate_q <= lane_kbps;
                        if (ref_khz == '0) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            word_q <= '0;
                            pll_q  <= '0;
                            lp_q   <= '0;
                        end else begin
                            srch_go_q <= 1'b1;
                            state_q   <= ST_SEARCH;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (srch_fin) begin
                        pdiv_q   <= srch_pdiv;
                        dvd_q    <= ceil_dvd;
                        dvs_q    <= WIDE_W'(ref_q);
                        div_go_q <= 1'b1;
                        state_q  <= ST_MULT;
                    end
                end
                ST_MULT: begin
                    if (div_fin) begin
                        mfield_q <= quot[MULT_W-1:0];
                        dvd_q    <= full_dvd;
                        dvs_q    <= WIDE_W'(pdiv_q);
                        div_go_q <= 1'b1;
                        state_q  <= ST_FULL;
                    end
                end
                ST_FULL: begin
                    if (div_fin) begin
                        band_q   <= quot_band;
                        dvd_q    <= field_dvd;
                        dvs_q    <= WIDE_W'(pdiv_q);
                        div_go_q <= 1'b1;
                        state_q  <= ST_FIELD;
                    end
                end
                ST_FIELD: begin
                    if (div_fin) begin
                        pllf_q   <= quot[PLL_W-1:0];
                        dvd_q    <= lp_dvd;
                        dvs_q    <= WIDE_W'(LP_STEP_KHZ);
                        div_go_q <= 1'b1;
                        state_q  <= ST_LP;
                    end
                end
                ST_LP: begin
                    if (div_fin) begin
                        word_q.band   <= band_q;
                        word_q.rsvd   <= 1'b0;
                        word_q.prediv <= pdiv_q;
                        word_q.mult   <= mfield_q;
                        pll_q         <= pllf_q;
                        lp_q          <= quot[LP_W-1:0] - LP_W'(1);
                        done_q        <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign cfg_word     = word_q;
    assign pll_khz      = pll_q;
    assign lp_div_field = lp_q;

    // R9: a result is never flagged while still calculating
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: outputs move only with a done pulse
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cfg_word) && $stable(pll_khz) && $stable(lp_div_field)));

    // R2: an error comes with done and a cleared word
    p_err_done_r2: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && cfg_word == '0 && pll_khz == '0));

    // R6: a good word has a zero spare bit and a nonzero pre-divider
    p_word_fields_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (!cfg_word[13] && cfg_word[12:8] != '0));

    // R1: a request taken in idle starts the calculation on the next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ref_khz != '0) |=> busy);

endmodule

// File: tb/tb_pllcfg_calc.sv
`timescale 1ns/1ps
module tb_pllcfg_calc;
    import pllcfg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] ref_khz = '0;
    logic [FREQ_W-1:0] lane_kbps = '0;
    logic              busy;
    logic              done;
    logic              err;
    logic [WORD_W-1:0] cfg_word;
    logic [PLL_W-1:0]  pll_khz;
    logic [LP_W-1:0]   lp_div_field;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pllcfg_calc dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .ref_khz      (ref_khz),
        .lane_kbps    (lane_kbps),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .cfg_word     (cfg_word),
        .pll_khz      (pll_khz),
        .lp_div_field (lp_div_field)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input longint r, input longint t,
                                  output longint word, output longint f, output longint lp);
        longint d;
        longint m;
        longint full;
        longint band;
        longint mf;
        longint mfe;
        d = 1;
        while (r / (d + 1) >= 5000) d++;
        if (d > 31) d = 31;
        m = (t * d + r - 1) / r;
        full = r * m / d;
        band = (full >= 501000) ? 3 : (full >= 251000) ? 2 : (full >= 126000) ? 1 : 0;
        mf = m & 255;
        mfe = (mf == 0) ? 1 : mf;
        f = r * mfe / d;
        lp = (((f + 79999) / 80000) - 1) & 63;
        word = (band << 14) | (d << 8) | mf;
    endfunction

    task automatic pulse_start(input longint r, input longint t);
        ref_khz   = FREQ_W'(r);
        lane_kbps = FREQ_W'(t);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(req, "done seen before timeout", longint'(done), 1);
    endtask

    task automatic t_reset();
        check("R10", "busy", longint'(busy), 0);
        check("R10", "done", longint'(done), 0);
        check("R10", "err", longint'(err), 0);
        check("R10", "cfg_word", longint'(cfg_word), 0);
        check("R10", "pll_khz", longint'(pll_khz), 0);
        check("R10", "lp_div_field", longint'(lp_div_field), 0);
    endtask

    task automatic run_case(input string req, input longint r, input longint t);
        longint ew;
        longint ef;
        longint el;
        model(r, t, ew, ef, el);
        pulse_start(r, t);
        check("R1", "busy after start", longint'(busy), 1);
        wait_done(req);
        check("R9", "err on good result", longint'(err), 0);
        check("R9", "busy low with done", longint'(busy), 0);
        check(req, "cfg_word", longint'(cfg_word), ew);
        check("R7", "pll_khz", longint'(pll_khz), ef);
        check("R8", "lp_div_field", longint'(lp_div_field), el);
        @(negedge clk);
        check("R9", "done one cycle", longint'(done), 0);
        check("R9", "word held", longint'(cfg_word), ew);
    endtask

    // R3 R4 R5 R6 R7 R8: hand-worked pair, P=4, M=100, F=500000
    task automatic t_known();
        pulse_start(20000, 500000);
        wait_done("R6");
        check("R6", "known word", longint'(cfg_word), 64'h8464);
        check("R7", "known pll", longint'(pll_khz), 500000);
        check("R8", "known lp field", longint'(lp_div_field), 6);
        @(negedge clk);
    endtask

    task automatic t_search();
        run_case("R3", 8000, 400000);
        run_case("R3", 200000, 800000);
        run_case("R3", 1000000, 900000);
    endtask

    task automatic t_bands();
        run_case("R5", 3000, 501000);
        run_case("R5", 3000, 498000);
        run_case("R5", 1000, 251000);
        run_case("R5", 1000, 250000);
        run_case("R5", 1000, 126000);
        run_case("R5", 1000, 125000);
    endtask

    task automatic t_mult_edges();
        run_case("R4", 1000, 1000000);
        run_case("R7", 20000, 0);
        run_case("R8", 27000, 1000000);
    endtask

    task automatic t_err();
        pulse_start(0, 500000);
        check("R2", "done", longint'(done), 1);
        check("R2", "err", longint'(err), 1);
        check("R2", "busy", longint'(busy), 0);
        check("R2", "cfg_word", longint'(cfg_word), 0);
        check("R2", "pll_khz", longint'(pll_khz), 0);
        check("R2", "lp_div_field", longint'(lp_div_field), 0);
        @(negedge clk);
        check("R2", "err one cycle", longint'(err), 0);
    endtask

    task automatic t_hold();
        longint ew;
        longint ef;
        longint el;
        model(27000, 600000, ew, ef, el);
        pulse_start(27000, 600000);
        wait_done("R9");
        @(negedge clk);
        ref_khz   = FREQ_W'(5000);
        lane_kbps = FREQ_W'(123000);
        repeat (20) @(negedge clk);
        check("R9", "word held idle", longint'(cfg_word), ew);
        check("R9", "pll held idle", longint'(pll_khz), ef);
        check("R9", "lp held idle", longint'(lp_div_field), el);
    endtask

    task automatic t_busy_ignore();
        longint ew;
        longint ef;
        longint el;
        model(20000, 700000, ew, ef, el);
        pulse_start(20000, 700000);
        repeat (6) @(negedge clk);
        pulse_start(3000, 501000);
        check("R1", "still busy", longint'(busy), 1);
        wait_done("R1");
        check("R1", "word from first request", longint'(cfg_word), ew);
        check("R1", "pll from first request", longint'(pll_khz), ef);
        @(negedge clk);
        check("R1", "no second result", longint'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_known();
        t_search();
        t_bands();
        t_mult_edges();
        t_err();
        t_hold();
        t_busy_ignore();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule